// File: doc/BRIEF.md
# Serial Program Loader for a Writable Instruction Memory

This block fills a small writable instruction store from a stream of bytes delivered by a UART receiver. While the load-mode input is high, it waits for a start marker of 0xA5 and ignores any other byte. It then takes the next byte as the number of 32-bit words to load. After that, it gathers the data bytes four at a time, least significant byte first, and writes each finished word to the memory through a single write port.

The write port is driven combinationally. A word is committed in the same cycle that its fourth byte is presented. Two registered status outputs report the load. The busy output is meant to hold the processor in reset while a load is in progress. The done output reports that the requested words have all been written. Dropping load mode returns the loader to idle at any point. The UART receiver, the memory array and the processor sit outside this block.

Top module: `prog_loader`

## Requirements
- R1: After a synchronous reset, wr_en, busy and done are all 0.
- R2: While load_en is 0, no byte causes a write and busy and done stay 0. Lowering load_en in any state returns the loader to idle by the next clock edge, with busy and done at 0. A later load starts again at word address 0 and byte lane 0.
- R3: While the loader waits for the start marker, every received byte other than 0xA5 is discarded without effect.
- R4: The byte received after 0xA5 is the word count N. busy rises on the clock edge that accepts 0xA5 and stays high until the edge that commits the last word.
- R5: Data bytes are little-endian within a word. The k-th byte of a word (k = 0..3) lands in wr_data bits 8k+7:8k.
- R6: wr_en is high only in a cycle where rx_valid is high, the loader is reading data, and the presented byte is the fourth byte of a word. It is never high at any other time.
- R7: wr_addr starts at 0 for the first word of a load and increases by one after each committed word.
- R8: On the edge that commits word N, done rises and busy falls. done stays high, and further bytes cause no writes, until load_en drops.
- R9: A count of 0 sends the loader straight to done with no write.
- R10: A count above 32 is treated as 32. Exactly 32 words are written, to addresses 0 to 31.
- R11: Cycles with rx_valid low change neither the byte lane nor the word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load-mode enable |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| wr_en | output | 1 | Instruction memory write strobe |
| wr_addr | output | 5 | Instruction memory word address |
| wr_data | output | 32 | Instruction memory write data |
| busy | output | 1 | Load in progress (hold processor in reset) |
| done | output | 1 | All requested words written |

## Verification
A table of loads is replayed through a behavioural memory. Each load varies the junk byte in front of the marker, the word count (1, small, mid-size and full depth) and the word patterns, and some loads leave idle gaps between bytes. Together these separate a correct byte-lane order from a swapped one, a correct address step from a stuck or skipped one, and correct gap handling from a counter that moves on idle cycles. Directed cases then check, byte by byte, when the write strobe fires. They also check a zero count, a clamped oversize count with trailing bytes, bytes sent with load mode off, and an abort partway through a load followed by a clean restart.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_HUNT,
    LD_COUNT,
    LD_DATA,
    LD_FULL
  } ld_state_t;
endpackage

// File: rtl/ldr_byte_asm.sv
module ldr_byte_asm #(
  parameter int BYTE_W = 8,
  parameter int BPW    = 4,
  localparam int LANE_W = $clog2(BPW),
  localparam int WORD_W = BYTE_W * BPW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              last_lane,
  output logic [WORD_W-1:0] word_out
);
  logic [LANE_W-1:0] lane_q;
  logic [BYTE_W-1:0] hold_q [BPW-1];

  always_ff @(posedge clk) begin
    if (rst || clear) lane_q <= '0;
    else if (take)    lane_q <= (lane_q == LANE_W'(BPW-1)) ? '0 : lane_q + 1'b1;
  end

  for (genvar k = 0; k < BPW-1; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                              hold_q[k] <= '0;
      else if (take && lane_q == LANE_W'(k)) hold_q[k] <= byte_in;
    end
  end

  always_comb begin
    last_lane = (lane_q == LANE_W'(BPW-1));
    word_out  = '0;
    for (int k = 0; k < BPW-1; k++) word_out[k*BYTE_W +: BYTE_W] = hold_q[k];
    word_out[(BPW-1)*BYTE_W +: BYTE_W] = byte_in;
  end

  AST_LANE_RESTART: assert property (@(posedge clk) disable iff (rst)
    clear |=> !last_lane) else $error("lane not restarted"); // R2
  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!take && !clear) |=> $stable(lane_q)) else $error("lane moved without byte"); // R11
endmodule

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import loader_pkg::*;
#(
  parameter int              DEPTH  = 32,
  parameter int              BYTE_W = 8,
  parameter int              WORD_W = 32,
  parameter logic [BYTE_W-1:0] MAGIC = 8'hA5,
  localparam int             ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              last_lane,
  input  logic [WORD_W-1:0] asm_word,
  output logic              take,
  output logic              clear,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  ld_state_t         state_q, state_d;
  logic [ADDR_W-1:0] word_idx, last_idx, clamp;

  // one process owns the whole write port
  always_comb begin
    wr_en   = (state_q == LD_DATA) && last_lane && rx_valid;
    wr_addr = word_idx;
    wr_data = asm_word;
  end

  always_comb begin
    take  = (state_q == LD_DATA) && rx_valid;
    clear = (state_q != LD_DATA);
    if (int'(rx_byte) > DEPTH) clamp = ADDR_W'(DEPTH - 1);
    else                       clamp = ADDR_W'(int'(rx_byte) - 1);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_IDLE:  if (load_en) state_d = LD_HUNT;
      LD_HUNT:  if (rx_valid && rx_byte == MAGIC) state_d = LD_COUNT;
      LD_COUNT: if (rx_valid) state_d = (rx_byte == '0) ? LD_FULL : LD_DATA;
      LD_DATA:  if (wr_en && word_idx == last_idx) state_d = LD_FULL;
      LD_FULL:  state_d = LD_FULL;
      default:  state_d = LD_IDLE;
    endcase
    if (!load_en) state_d = LD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= LD_IDLE;
      word_idx <= '0;
      last_idx <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      state_q <= state_d;
      busy    <= (state_d == LD_COUNT) || (state_d == LD_DATA);
      done    <= (state_d == LD_FULL);
      if (state_q == LD_COUNT && rx_valid) begin
        word_idx <= '0;
        last_idx <= clamp;
      end else if (wr_en) begin
        word_idx <= word_idx + 1'b1;
      end
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> (!busy && !done)) else $error("not idle"); // R2
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)) else $error("busy and done"); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && load_en) |=> (done && !wr_en)) else $error("done lost"); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && state_d == LD_DATA) |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1))
    else $error("address step"); // R7
  AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy) else $error("write outside load"); // R6
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && load_en && state_q != LD_IDLE) |=> ($stable(state_q) && $stable(word_idx)))
    else $error("advanced on idle cycle"); // R11
endmodule

// File: rtl/prog_loader.sv
module prog_loader #(
  parameter int              DEPTH  = 32,
  parameter int              WORD_W = 32,
  parameter int              BYTE_W = 8,
  parameter logic [BYTE_W-1:0] MAGIC = 8'hA5,
  localparam int             BPW    = WORD_W / BYTE_W,
  localparam int             ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  logic              take, clear, last_lane;
  logic [WORD_W-1:0] asm_word;

  ldr_byte_asm #(.BYTE_W(BYTE_W), .BPW(BPW)) i_asm (
    .clk(clk), .rst(rst), .clear(clear), .take(take), .byte_in(rx_byte),
    .last_lane(last_lane), .word_out(asm_word)
  );

  ldr_ctrl #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .WORD_W(WORD_W), .MAGIC(MAGIC)) i_ctrl (
    .clk(clk), .rst(rst), .load_en(load_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .last_lane(last_lane), .asm_word(asm_word), .take(take), .clear(clear),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
  );

  AST_WE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> rx_valid) else $error("write without byte"); // R6
endmodule

// File: tb/test_prog_loader.sv
module test_prog_loader;
  logic        clk = 0, rst = 1, load_en = 0, rx_valid = 0;
  logic [7:0]  rx_byte = 0;
  logic        wr_en, busy, done;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;

  int nchk = 0, nerr = 0;
  logic [31:0] mem [32];
  int   nwr = 0;
  logic clr_mem = 0;
  logic        s_we;
  logic [4:0]  s_addr;
  logic [31:0] s_data;

  always #4 clk = ~clk;

  prog_loader i_prog_loader (
    .clk(clk), .rst(rst), .load_en(load_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (clr_mem) begin
      for (int i = 0; i < 32; i++) mem[i] <= 32'hDEADBEEF;
      nwr <= 0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
      nwr <= nwr + 1;
    end
  end

  // {junk prefix, count, seed}
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'd1,  16'h1234}, {8'h3C, 8'd3,  16'hBEEF},
    {8'hA4, 8'd8,  16'h0F0F}, {8'h5A, 8'd32, 16'h7777},
    {8'hFF, 8'd2,  16'hC001}, {8'h00, 8'd5,  16'h4242}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(logic [15:0] seed, int i);
    logic [7:0] b = 8'(i);
    return {seed, seed ^ 16'h5A3C} ^ {b + 8'h11, b, ~b, 8'(b * 3)};
  endfunction

  task automatic send(logic [7:0] b, int gap = 0);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    #1;
    s_we = wr_en; s_addr = wr_addr; s_data = wr_data;
    @(posedge clk); #1;
    rx_valid = 0;
    for (int g = 0; g < gap; g++) @(posedge clk);
    #1;
  endtask

  task automatic send_word(logic [31:0] w, int gap = 0);
    for (int k = 0; k < 4; k++) send(w[8*k +: 8], gap);
  endtask

  task automatic restart();
    @(negedge clk); load_en = 0; clr_mem = 1;
    @(negedge clk); clr_mem = 0; load_en = 1;
    @(posedge clk); #1;
  endtask

  task automatic check_mem(string req, int eff, logic [15:0] seed);
    int bad = 0;
    logic [31:0] a = 0, e = 0;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] x = (i < eff) ? gen(seed, i) : 32'hDEADBEEF;
      if (mem[i] !== x && bad == 0) begin a = mem[i]; e = x; end
      if (mem[i] !== x) bad++;
    end
    check(req, a, e);
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; clr_mem = 1;
    @(negedge clk); clr_mem = 0;
    check("R1 wr_en", 32'(wr_en), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);

    // table: R3 prefix, R4 busy, R5/R7 contents, R8 done, R11 gaps
    foreach (VEC[v]) begin
      int n = int'(VEC[v][23:16]);
      logic [15:0] sd = VEC[v][15:0];
      int gap = v % 2;
      restart();
      send(VEC[v][31:24], gap);
      check("R3 junk ignored", 32'(busy), 0);
      send(8'hA5, gap);
      check("R4 busy after marker", 32'(busy), 1);
      send(8'(n), gap);
      for (int i = 0; i < n; i++) send_word(gen(sd, i), gap);
      check("R8 done", {31'b0, done}, 1);
      check("R8 busy low", {31'b0, busy}, 0);
      check("R7 write count", 32'(nwr), 32'(n));
      check_mem("R5 R7 R11 contents", n, sd);
    end

    // R6: strobe only on fourth byte, R5 lane order
    restart();
    send(8'hA5); send(8'd2);
    send(8'h11); check("R6 byte0 no write", 32'(s_we), 0);
    send(8'h22); check("R6 byte1 no write", 32'(s_we), 0);
    send(8'h33); check("R6 byte2 no write", 32'(s_we), 0);
    send(8'h44); check("R6 byte3 write", 32'(s_we), 1);
    check("R5 data", s_data, 32'h44332211);
    check("R7 addr0", 32'(s_addr), 0);
    send(8'h55); send(8'h66); send(8'h77); send(8'h88);
    check("R7 addr1", 32'(s_addr), 1);
    check("R5 data2", s_data, 32'h88776655);
    send(8'h99); send(8'h99); send(8'h99); send(8'h99);
    check("R8 no write after done", 32'(s_we), 0);
    check("R8 done held", 32'(done), 1);

    // R9 zero count
    restart();
    send(8'hA5); send(8'd0);
    check("R9 done", 32'(done), 1);
    check("R9 busy", 32'(busy), 0);
    check("R9 no write", 32'(nwr), 0);

    // R10 clamp
    restart();
    send(8'hA5); send(8'd40);
    for (int i = 0; i < 40; i++) send_word(gen(16'h3141, i));
    check("R10 writes", 32'(nwr), 32);
    check("R10 done", 32'(done), 1);
    check_mem("R10 contents", 32, 16'h3141);

    // R2 load_en low: no effect
    restart();
    @(negedge clk); load_en = 0;
    send(8'hA5); send(8'd1); send_word(32'h01020304);
    check("R2 no write while off", 32'(nwr), 0);
    check("R2 busy off", 32'(busy), 0);
    check("R2 done off", 32'(done), 0);

    // R2 abort mid-load and restart clean
    restart();
    send(8'hA5); send(8'd3);
    send_word(32'hCAFEF00D); send(8'hEE);
    @(negedge clk); load_en = 0;
    @(posedge clk); #1;
    check("R2 abort busy", 32'(busy), 0);
    check("R2 abort done", 32'(done), 0);
    restart();
    send(8'hA5); send(8'd1);
    send_word(32'hA1B2C3D4);
    check("R2 restart addr", 32'(s_addr), 0);
    check("R2 restart data", s_data, 32'hA1B2C3D4);
    check("R2 restart done", 32'(done), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule